// File: doc/BRIEF.md
# Multi-cycle stack machine core

This block is a small multi-cycle processor for a stack-oriented instruction set. Code and data share one word-addressed synchronous RAM inside the block. Each instruction occupies three consecutive words: an opcode, a nesting level and an operand. The data stack lives at the top of the same RAM and grows toward lower addresses. The core keeps a program counter, a frame base pointer, a stack pointer and a three-field instruction register. It steps through a fetch phase and then an execute phase for every instruction.

Procedures get activation records that hold three link words: a static link, a dynamic link and a return address. Variables in enclosing scopes are reached by following the static links, one RAM read per level. Program I/O uses three system calls. Output is a one-cycle valid strobe with the value. Input is a request that waits for a valid strobe. The third call is a sticky halt. The testbench fills the RAM through a preload write port while the core is held in reset.

Top module: `stk_core`

## Requirements
- R1: While rst_n is low the core shows pc_o = 0, bp_o = DEPTH-1 (499), sp_o = DEPTH (500), and halted is 0. Execution starts from address 0 when rst_n rises.
- R2: An instruction is the word triple (opcode, level, operand) at pc, pc+1 and pc+2. After the fetch, pc has advanced by 3. Opcode values are 1 push-literal, 2 operate, 3 load, 4 store, 5 call, 6 allocate, 7 jump, 8 jump-if-zero, 9 system call. Any other opcode does nothing beyond the fetch.
- R3: Push-literal (1) decrements sp and then writes the operand at the new sp. System call 9 with operand 1 pulses out_valid for one cycle with the top word on out_data, and pops that word (sp+1).
- R4: Operate (2) with a nonzero operand pops two words. The left operand is the deeper word and the right operand is the top word. The result is written over the deeper word, so sp grows by 1. Function codes are 2 add, 3 subtract, 4 multiply, 5 equal, 6 not-equal, 7 less, 8 less-or-equal, 9 greater, 10 greater-or-equal. Arithmetic wraps at 32 bits two's complement. Comparisons are signed and give 1 or 0. Any other function code gives 0.
- R5: Load (3) pushes the word at address base(L) - M. Store (4) pops the top word into base(L) - M. Here base(0) is bp, and base(L) is the word stored at address base(L-1).
- R6: Call (5) writes base(L) at sp-1 (static link), bp at sp-2 (dynamic link) and the return pc at sp-3. It then sets bp = sp-1 and pc = M, and leaves sp unchanged. Allocate (6) subtracts M from sp.
- R7: Operate with operand 0 returns. It sets sp = bp+1, takes bp from address bp-1 and pc from address bp-2.
- R8: Jump (7) sets pc = M. Jump-if-zero (8) pops the top word and sets pc = M only when that word is 0.
- R9: System call 9 with operand 2 holds in_req high until in_valid is high. While it waits, pc and sp do not change. It then pushes in_data.
- R10: System call 9 with operand 3 raises halted. From then on halted stays high and pc, bp and sp stay unchanged until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the core registers |
| pre_we | input | 1 | Preload write enable, takes priority over core writes |
| pre_addr | input | AW (9) | Preload word address |
| pre_data | input | WORD (32) | Preload word |
| in_valid | input | 1 | Input value present for a pending input request |
| in_data | input | WORD (32) | Input value |
| in_req | output | 1 | Core waits for an input value |
| out_valid | output | 1 | One-cycle strobe of an output value |
| out_data | output | WORD (32) | Output value, meaningful with out_valid |
| halted | output | 1 | Program has executed the halt call |
| pc_o | output | AW (9) | Program counter |
| bp_o | output | AW (9) | Frame base pointer |
| sp_o | output | AW (9) | Stack pointer |

## Verification
The bench uses the default parameters: a 32-bit word and 500 words of RAM. With 32-bit words, overflow on add and multiply and signed comparisons across the sign bit can be tested with literal operands. The 500-word RAM gives the exact start values 499 and 500 and a three-level nesting of activation records. The nested-call program reads the link words back through level-0 loads, and reaches an outer variable through a two-level static-link walk.

// File: rtl/stk_pkg.sv
package stk_pkg;
    // opcode values (low nibble of the opcode word)
    localparam logic [3:0] OPC_LIT = 4'd1;
    localparam logic [3:0] OPC_OPR = 4'd2;
    localparam logic [3:0] OPC_LOD = 4'd3;
    localparam logic [3:0] OPC_STO = 4'd4;
    localparam logic [3:0] OPC_CAL = 4'd5;
    localparam logic [3:0] OPC_INC = 4'd6;
    localparam logic [3:0] OPC_JMP = 4'd7;
    localparam logic [3:0] OPC_JPC = 4'd8;
    localparam logic [3:0] OPC_SYS = 4'd9;

    // operate function codes
    localparam logic [3:0] FN_ADD = 4'd2;
    localparam logic [3:0] FN_SUB = 4'd3;
    localparam logic [3:0] FN_MUL = 4'd4;
    localparam logic [3:0] FN_EQ  = 4'd5;
    localparam logic [3:0] FN_NE  = 4'd6;
    localparam logic [3:0] FN_LT  = 4'd7;
    localparam logic [3:0] FN_LE  = 4'd8;
    localparam logic [3:0] FN_GT  = 4'd9;
    localparam logic [3:0] FN_GE  = 4'd10;

    typedef enum logic [4:0] {
        S_F0, S_F1, S_F2, S_F3, S_EX, S_WALK,
        S_LD1, S_LD2, S_ST1, S_ST2,
        S_CL1, S_CL2, S_CL3,
        S_OP1, S_OP2, S_RT1, S_RT2,
        S_JP1, S_OUT, S_IN, S_HALT
    } state_e;
endpackage

// File: rtl/stk_ram.sv
module stk_ram #(
    parameter int WORD  = 32,
    parameter int DEPTH = 500,
    parameter int AW    = 9
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [WORD-1:0] wd,
    input  logic [AW-1:0]   ra,
    output logic [WORD-1:0] rd
);
    logic [WORD-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(wa) < DEPTH)) mem_q[wa] <= wd;
        if (int'(ra) < DEPTH) rd <= mem_q[ra];
        else                  rd <= '0;
    end
endmodule

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int WORD = 32
) (
    input  logic [WORD-1:0] lhs,
    input  logic [WORD-1:0] rhs,
    input  logic [WORD-1:0] fn,
    output logic [WORD-1:0] res
);
    logic       fn_hi;
    logic [3:0] fsel;
    logic       is_cmp;

    assign fn_hi  = |fn[WORD-1:4];
    assign fsel   = fn[3:0];
    assign is_cmp = !fn_hi && (fsel >= FN_EQ) && (fsel <= FN_GE);

    always_comb begin
        res = '0;
        if (!fn_hi) begin
            case (fsel)
                FN_ADD: res = lhs + rhs;
                FN_SUB: res = lhs - rhs;
                FN_MUL: res = lhs * rhs;
                FN_EQ:  res = WORD'(lhs == rhs);
                FN_NE:  res = WORD'(lhs != rhs);
                FN_LT:  res = WORD'($signed(lhs) <  $signed(rhs));
                FN_LE:  res = WORD'($signed(lhs) <= $signed(rhs));
                FN_GT:  res = WORD'($signed(lhs) >  $signed(rhs));
                FN_GE:  res = WORD'($signed(lhs) >= $signed(rhs));
                default: res = '0;
            endcase
        end
    end

    always_comb begin
        if (is_cmp) begin
            AST_CMP_BOOL: assert (res == '0 || res == WORD'(1)); // R4
        end
    end
endmodule

// File: rtl/stk_core.sv
module stk_core
    import stk_pkg::*;
#(
    parameter int WORD  = 32,
    parameter int DEPTH = 500,
    localparam int AW      = $clog2(DEPTH + 1),
    localparam int BP_INIT = DEPTH - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pre_we,
    input  logic [AW-1:0]   pre_addr,
    input  logic [WORD-1:0] pre_data,
    input  logic            in_valid,
    input  logic [WORD-1:0] in_data,
    output logic            in_req,
    output logic            out_valid,
    output logic [WORD-1:0] out_data,
    output logic            halted,
    output logic [AW-1:0]   pc_o,
    output logic [AW-1:0]   bp_o,
    output logic [AW-1:0]   sp_o
);
    typedef struct packed {
        state_e          st;
        logic [AW-1:0]   pc;
        logic [AW-1:0]   bp;
        logic [AW-1:0]   sp;
        logic [AW-1:0]   walk;
        logic [WORD-1:0] op;
        logic [WORD-1:0] lv;
        logic [WORD-1:0] m;
        logic [WORD-1:0] tmp;
        logic [WORD-1:0] cnt;
    } core_t;

    localparam core_t RST_V = '{
        st: S_F0, pc: '0, bp: AW'(BP_INIT), sp: AW'(BP_INIT + 1),
        walk: '0, op: '0, lv: '0, m: '0, tmp: '0, cnt: '0
    };

    core_t q, d;

    logic            c_we;
    logic [AW-1:0]   c_wa;
    logic [WORD-1:0] c_wd;
    logic [AW-1:0]   rd_addr;
    logic [WORD-1:0] rd_data;
    logic [WORD-1:0] alu_res;

    logic            mem_we;
    logic [AW-1:0]   mem_wa;
    logic [WORD-1:0] mem_wd;

    assign mem_we = pre_we | c_we;
    assign mem_wa = pre_we ? pre_addr : c_wa;
    assign mem_wd = pre_we ? pre_data : c_wd;

    stk_ram #(.WORD(WORD), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk (clk),
        .we  (mem_we),
        .wa  (mem_wa),
        .wd  (mem_wd),
        .ra  (rd_addr),
        .rd  (rd_data)
    );

    stk_alu #(.WORD(WORD)) u_alu (
        .lhs (rd_data),
        .rhs (q.tmp),
        .fn  (q.m),
        .res (alu_res)
    );

    logic          op_hi;
    logic [3:0]    opc;
    logic [AW-1:0] mw;

    assign op_hi = |q.op[WORD-1:4];
    assign opc   = q.op[3:0];
    assign mw    = q.m[AW-1:0];

    function automatic state_e walk_target(input logic [3:0] o);
        case (o)
            OPC_LOD: return S_LD1;
            OPC_STO: return S_ST1;
            default: return S_CL1;
        endcase
    endfunction

    function automatic logic [WORD-1:0] widen(input logic [AW-1:0] a);
        return {{(WORD-AW){1'b0}}, a};
    endfunction

    always_comb begin
        d         = q;
        rd_addr   = q.sp;
        c_we      = 1'b0;
        c_wa      = q.sp;
        c_wd      = '0;
        out_valid = 1'b0;
        in_req    = 1'b0;
        case (q.st)
            S_F0: begin
                rd_addr = q.pc;
                d.st    = S_F1;
            end
            S_F1: begin
                d.op    = rd_data;
                rd_addr = q.pc + AW'(1);
                d.st    = S_F2;
            end
            S_F2: begin
                d.lv    = rd_data;
                rd_addr = q.pc + AW'(2);
                d.st    = S_F3;
            end
            S_F3: begin
                d.m  = rd_data;
                d.pc = q.pc + AW'(3);
                d.st = S_EX;
            end
            S_EX: begin
                d.st = S_F0;
                if (!op_hi) begin
                    case (opc)
                        OPC_LIT: begin
                            c_we = 1'b1;
                            c_wa = q.sp - AW'(1);
                            c_wd = q.m;
                            d.sp = q.sp - AW'(1);
                        end
                        OPC_OPR: begin
                            if (q.m == '0) begin
                                rd_addr = q.bp - AW'(1);
                                d.st    = S_RT1;
                            end else begin
                                d.st    = S_OP1;
                            end
                        end
                        OPC_LOD, OPC_STO, OPC_CAL: begin
                            d.walk = q.bp;
                            d.cnt  = q.lv;
                            if (q.lv == '0) begin
                                d.st = walk_target(opc);
                            end else begin
                                rd_addr = q.bp;
                                d.st    = S_WALK;
                            end
                        end
                        OPC_INC: d.sp = q.sp - mw;
                        OPC_JMP: d.pc = mw;
                        OPC_JPC: d.st = S_JP1;
                        OPC_SYS: begin
                            if (q.m == WORD'(1))      d.st = S_OUT;
                            else if (q.m == WORD'(2)) d.st = S_IN;
                            else if (q.m == WORD'(3)) d.st = S_HALT;
                        end
                        default: d.st = S_F0;
                    endcase
                end
            end
            S_WALK: begin
                d.walk = rd_data[AW-1:0];
                d.cnt  = q.cnt - WORD'(1);
                if (q.cnt == WORD'(1)) begin
                    d.st = walk_target(opc);
                end else begin
                    rd_addr = rd_data[AW-1:0];
                end
            end
            S_LD1: begin
                rd_addr = q.walk - mw;
                d.st    = S_LD2;
            end
            S_LD2: begin
                c_we = 1'b1;
                c_wa = q.sp - AW'(1);
                c_wd = rd_data;
                d.sp = q.sp - AW'(1);
                d.st = S_F0;
            end
            S_ST1: d.st = S_ST2;
            S_ST2: begin
                c_we = 1'b1;
                c_wa = q.walk - mw;
                c_wd = rd_data;
                d.sp = q.sp + AW'(1);
                d.st = S_F0;
            end
            S_CL1: begin
                c_we = 1'b1;
                c_wa = q.sp - AW'(1);
                c_wd = widen(q.walk);
                d.st = S_CL2;
            end
            S_CL2: begin
                c_we = 1'b1;
                c_wa = q.sp - AW'(2);
                c_wd = widen(q.bp);
                d.st = S_CL3;
            end
            S_CL3: begin
                c_we = 1'b1;
                c_wa = q.sp - AW'(3);
                c_wd = widen(q.pc);
                d.bp = q.sp - AW'(1);
                d.pc = mw;
                d.st = S_F0;
            end
            S_OP1: begin
                d.tmp   = rd_data;
                rd_addr = q.sp + AW'(1);
                d.st    = S_OP2;
            end
            S_OP2: begin
                c_we = 1'b1;
                c_wa = q.sp + AW'(1);
                c_wd = alu_res;
                d.sp = q.sp + AW'(1);
                d.st = S_F0;
            end
            S_RT1: begin
                d.tmp   = rd_data;
                rd_addr = q.bp - AW'(2);
                d.st    = S_RT2;
            end
            S_RT2: begin
                d.pc = rd_data[AW-1:0];
                d.sp = q.bp + AW'(1);
                d.bp = q.tmp[AW-1:0];
                d.st = S_F0;
            end
            S_JP1: begin
                if (rd_data == '0) d.pc = mw;
                d.sp = q.sp + AW'(1);
                d.st = S_F0;
            end
            S_OUT: begin
                out_valid = 1'b1;
                d.sp      = q.sp + AW'(1);
                d.st      = S_F0;
            end
            S_IN: begin
                in_req = 1'b1;
                if (in_valid) begin
                    c_we = 1'b1;
                    c_wa = q.sp - AW'(1);
                    c_wd = in_data;
                    d.sp = q.sp - AW'(1);
                    d.st = S_F0;
                end
            end
            S_HALT: d.st = S_HALT;
            default: d.st = S_F0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_V;
        else        q <= d;
    end

    assign out_data = rd_data;
    assign halted   = (q.st == S_HALT);
    assign pc_o     = q.pc;
    assign bp_o     = q.bp;
    assign sp_o     = q.sp;

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_F3) |=> (q.pc == $past(q.pc) + AW'(3))); // R2
    AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R3
    AST_WALK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WALK) |-> (q.cnt != '0)); // R5
    AST_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req && !in_valid) |=> (in_req && $stable(q.sp) && $stable(q.pc))); // R9
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(q.pc) && $stable(q.sp) && $stable(q.bp))); // R10
endmodule

// File: tb/sim_stk_core.sv
module sim_stk_core;
    localparam int WORD  = 32;
    localparam int DEPTH = 500;
    localparam int AW    = $clog2(DEPTH + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pre_we = 1'b0;
    logic [AW-1:0]   pre_addr = '0;
    logic [WORD-1:0] pre_data = '0;
    logic            in_valid = 1'b0;
    logic [WORD-1:0] in_data = '0;
    logic            in_req, out_valid, halted;
    logic [WORD-1:0] out_data;
    logic [AW-1:0]   pc_o, bp_o, sp_o;

    stk_core #(.WORD(WORD), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .in_valid(in_valid), .in_data(in_data),
        .in_req(in_req), .out_valid(out_valid), .out_data(out_data),
        .halted(halted), .pc_o(pc_o), .bp_o(bp_o), .sp_o(sp_o)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    logic [WORD-1:0] prog [DEPTH];
    logic [WORD-1:0] outs [16];
    int              nout = 0;
    logic [WORD-1:0] in_q [4];
    int              in_idx = 0;
    int              in_delay = 3;
    int              wait_cnt = 0;
    logic            wait_bad = 1'b0;
    logic [AW-1:0]   sp_hold = '0;
    logic [AW-1:0]   pc_hold = '0;

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run hung, act=%0d exp<%0d", cyc, 190000);
            summary();
            $finish;
        end
    end

    // output monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && nout < 16) begin
            outs[nout] = out_data;
            nout++;
        end
    end

    // input responder
    always @(negedge clk) begin
        if (in_valid) begin
            in_valid = 1'b0;
            in_idx++;
            wait_cnt = 0;
        end else if (rst_n && in_req) begin
            if (wait_cnt == 0) begin
                sp_hold = sp_o;
                pc_hold = pc_o;
            end else if (sp_o != sp_hold || pc_o != pc_hold) begin
                wait_bad = 1'b1;
            end
            if (wait_cnt == in_delay) begin
                in_valid = 1'b1;
                in_data  = in_q[in_idx];
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [WORD-1:0] act, input logic [WORD-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < DEPTH; i++) prog[i] = '0;
    endtask

    task automatic put(input int idx, input int op, input int lv, input logic [WORD-1:0] m);
        prog[3*idx]   = WORD'(op);
        prog[3*idx+1] = WORD'(lv);
        prog[3*idx+2] = m;
    endtask

    function automatic logic [WORD-1:0] ref_op(input int fn, input logic [WORD-1:0] a,
                                               input logic [WORD-1:0] b);
        case (fn)
            2:  return a + b;
            3:  return a - b;
            4:  return a * b;
            5:  return WORD'(a == b);
            6:  return WORD'(a != b);
            7:  return WORD'($signed(a) <  $signed(b));
            8:  return WORD'($signed(a) <= $signed(b));
            9:  return WORD'($signed(a) >  $signed(b));
            10: return WORD'($signed(a) >= $signed(b));
            default: return '0;
        endcase
    endfunction

    task automatic run_prog(input int limit);
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            pre_we   = 1'b1;
            pre_addr = AW'(i);
            pre_data = prog[i];
        end
        @(negedge clk);
        pre_we   = 1'b0;
        nout     = 0;
        in_idx   = 0;
        wait_cnt = 0;
        wait_bad = 1'b0;
        rst_n    = 1'b1;
        for (int k = 0; k < limit && !halted; k++) @(negedge clk);
        check(halted == 1'b1, "R10 program reached halt", WORD'(halted), 1);
    endtask

    task automatic alu_case(input int fn, input logic [WORD-1:0] a, input logic [WORD-1:0] b);
        logic [WORD-1:0] e;
        clear_prog();
        put(0, 1, 0, a);
        put(1, 1, 0, b);
        put(2, 2, 0, WORD'(fn));
        put(3, 9, 0, 1);
        put(4, 9, 0, 3);
        run_prog(200);
        e = ref_op(fn, a, b);
        check(nout == 1, "R3 one output strobe", WORD'(nout), 1);
        check(outs[0] == e, $sformatf("R4 fn=%0d a=%0h b=%0h", fn, a, b), outs[0], e);
        check(sp_o == AW'(500), "R3 stack back to empty", WORD'(sp_o), 500);
        check(pc_o == AW'(15), "R2 pc after five fetches", WORD'(pc_o), 15);
    endtask

    initial begin
        int seed_dummy;
        int fn;
        logic [WORD-1:0] a, b;
        seed_dummy = $urandom(32'd24681);

        // R1 reset state
        repeat (3) @(negedge clk);
        check(pc_o == '0, "R1 pc reset", WORD'(pc_o), 0);
        check(bp_o == AW'(499), "R1 bp reset", WORD'(bp_o), 499);
        check(sp_o == AW'(500), "R1 sp reset", WORD'(sp_o), 500);
        check(halted == 1'b0, "R1 halted reset", WORD'(halted), 0);

        // directed operate corners R4
        alu_case(2, 32'h7fff_ffff, 32'h1);
        alu_case(4, 32'h0001_0001, 32'h0001_0001);
        alu_case(3, 32'h0, 32'h1);
        alu_case(10, 32'h5, 32'h5);
        alu_case(7, 32'hffff_fffe, 32'h1);
        alu_case(9, 32'h8000_0000, 32'h7fff_ffff);
        alu_case(1, 32'h3, 32'h4);
        alu_case(12, 32'h3, 32'h4);

        // random operate R4
        for (int t = 0; t < 24; t++) begin
            fn = 2 + int'($urandom % 9);
            a  = $urandom;
            b  = (t % 4 == 0) ? a : $urandom;
            alu_case(fn, a, b);
        end

        // nested calls, static-link walk, link words R5 R6 R7
        clear_prog();
        put(0, 6, 0, 4);    // reserve main frame, sp 496
        put(1, 1, 0, 7);
        put(2, 4, 0, 3);    // main var at 496 = 7
        put(3, 5, 0, 21);   // call P
        put(4, 3, 0, 3);    // load main var
        put(5, 9, 0, 1);
        put(6, 9, 0, 3);
        put(7, 6, 0, 3);    // P at 21
        put(8, 3, 1, 3);    // load outer var via one link
        put(9, 1, 0, 5);
        put(10, 2, 0, 2);   // add
        put(11, 4, 1, 3);   // store back to outer var
        put(12, 5, 0, 42);  // call Q
        put(13, 2, 0, 0);   // return from P (address 39)
        put(14, 6, 0, 3);   // Q at 42
        put(15, 3, 0, 0);   // static link
        put(16, 9, 0, 1);
        put(17, 3, 0, 1);   // dynamic link
        put(18, 9, 0, 1);
        put(19, 3, 0, 2);   // return address
        put(20, 9, 0, 1);
        put(21, 3, 2, 3);   // two-level walk to main var
        put(22, 1, 0, 3);
        put(23, 2, 0, 4);   // multiply
        put(24, 9, 0, 1);
        put(25, 2, 0, 0);   // return from Q
        run_prog(2000);
        check(nout == 5, "R6 output count nested", WORD'(nout), 5);
        check(outs[0] == 495, "R6 static link slot", outs[0], 495);
        check(outs[1] == 495, "R6 dynamic link slot", outs[1], 495);
        check(outs[2] == 39, "R6 return address slot", outs[2], 39);
        check(outs[3] == 36, "R5 two-level load", outs[3], 36);
        check(outs[4] == 12, "R5 store through static link", outs[4], 12);
        check(sp_o == AW'(496), "R7 sp after returns", WORD'(sp_o), 496);
        check(bp_o == AW'(499), "R7 bp after returns", WORD'(bp_o), 499);
        check(pc_o == AW'(21), "R7 pc resumed after call", WORD'(pc_o), 21);

        // jumps R8
        clear_prog();
        put(0, 1, 0, 0);
        put(1, 8, 0, 12);   // taken
        put(2, 1, 0, 66);
        put(3, 9, 0, 1);
        put(4, 1, 0, 1);    // at 12
        put(5, 8, 0, 27);   // not taken
        put(6, 1, 0, 4);
        put(7, 9, 0, 1);
        put(8, 7, 0, 33);
        put(9, 1, 0, 77);   // at 27, skipped
        put(10, 9, 0, 1);
        put(11, 9, 0, 3);   // at 33
        run_prog(500);
        check(nout == 1, "R8 only fall-through path prints", WORD'(nout), 1);
        check(outs[0] == 4, "R8 value on chosen path", outs[0], 4);
        check(sp_o == AW'(500), "R8 jump-if-zero pops", WORD'(sp_o), 500);

        // input handshake R9
        for (int t = 0; t < 3; t++) begin
            a = $urandom;
            b = $urandom;
            in_q[0] = a;
            in_q[1] = b;
            in_delay = 2 + t;
            clear_prog();
            put(0, 9, 0, 2);
            put(1, 9, 0, 2);
            put(2, 2, 0, 3);
            put(3, 9, 0, 1);
            put(4, 9, 0, 3);
            run_prog(500);
            check(outs[0] == a - b, "R9 input values pushed in order", outs[0], a - b);
            check(wait_bad == 1'b0, "R9 pc and sp frozen while waiting", WORD'(wait_bad), 0);
            check(in_idx == 2, "R9 two inputs consumed", WORD'(in_idx), 2);
        end

        // halt holds R10
        sp_hold = sp_o;
        pc_hold = pc_o;
        repeat (10) @(negedge clk);
        check(halted == 1'b1, "R10 halted stays high", WORD'(halted), 1);
        check(pc_o == pc_hold && sp_o == sp_hold, "R10 registers frozen",
              WORD'(pc_o), WORD'(pc_hold));
        check(in_req == 1'b0 && out_valid == 1'b0, "R10 no activity after halt",
              WORD'({in_req, out_valid}), 0);

        summary();
        $finish;
    end
endmodule